// File: doc/BRIEF.md
# Resolver Converter Host Sequencer

This block sits on the host side of a resolver-to-digital converter. It turns one-cycle requests into complete bus exchanges with the converter. Each exchange combines SPI byte transfers with two access-select pins, an active-low sample strobe and two resolution-select pins. A request is one of six operations: a position sample, a velocity sample, a configuration register write, a configuration register read, a fault read with clear, or a startup sequence. The startup sequence programs the control register, verifies it, loads the excitation frequency word and issues a soft reset.

Sample reads are framed by the strobe. The raw 16-bit word is reduced to the active resolution: position is shifted only when hysteresis is on, and velocity is always shifted and sign-extended. The active resolution and hysteresis setting are taken from the startup request and from any later write to the control register.

Top module: `rdc_host`

## Requirements
- R1: `modeSel` = {first select pin, second select pin} is 2'b00 for a position transfer, 2'b01 for velocity and 2'b10 for every configuration transfer. It is 2'b10 after reset and never changes while `csN` is low.
- R2: A register write (op 2) sends two one-byte transfers in configuration mode: `cmdAddr` with bit 7 set, then `cmdData` with bit 7 cleared.
- R3: A register read (op 3) is one two-byte transfer: `cmdAddr` with bit 7 set, then 0xFF. `result` becomes {8'h00, byte received in the second slot}.
- R4: In a sample read, `sampleN` goes low at least 6 converter clock periods plus 20 ns before `csN` falls. It goes high after the transfer and stays high at least 2 converter periods plus 20 ns before `done`. It is high whenever `busy` is low.
- R5: A velocity read (op 0 gives position, op 1 gives velocity) returns the raw big-endian word arithmetically shifted right by 16 minus the resolution, with the upper bits filled from raw bit 15.
- R6: A position read returns the raw word shifted right by 16 minus the resolution when hysteresis is on, and the raw word unchanged when it is off.
- R7: Resolution code k (0..3) means 10+2k bits and is driven on `resSel`. A write to address 0x92 sets the code from data bits [1:0] and hysteresis from data bit 4. Writes to any other address leave both unchanged. After reset the code is 1 and hysteresis is on.
- R8: Startup (op 5) sends, in order: 0x92, (0x7E with bits [1:0] replaced by `resCode`), a read of 0x92 (0x92, 0xFF), 0x91, `freqWord` with bit 7 cleared, 0xF0, 0x00. It sets the resolution to `resCode` and turns hysteresis on.
- R9: If bit 7 of the control read-back during startup is set, `initErr` is raised and the sequence ends without the remaining writes. A successful startup clears `initErr`.
- R10: A fault read (op 4) pulses `sampleN` low then high, reads register 0xFF as in R3, then pulses `sampleN` low and high again. That is two falling edges, and `result` is the fault byte.
- R11: The SPI link is mode 3. `sclk` is high whenever `csN` is high, `mosi` changes on falling edges, and `miso` is sampled on rising edges, most significant bit first.
- R12: A request is accepted only when `busy` is low. `cmdValid` while busy and op codes 6 and 7 are ignored. `done` is a one-cycle pulse at the end of each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Request strobe |
| cmdOp | input | 3 | Operation code (0 pos, 1 vel, 2 write, 3 read, 4 fault, 5 startup) |
| cmdAddr | input | 8 | Register address for write and read |
| cmdData | input | 8 | Register data for write |
| resCode | input | 2 | Resolution code used by startup |
| freqWord | input | 8 | Excitation frequency word used by startup |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Formatted sample or register byte |
| initErr | output | 1 | Startup read-back failure flag |
| modeSel | output | 2 | Access-select pins |
| sampleN | output | 1 | Active-low sample strobe |
| resSel | output | 2 | Resolution-select pins |
| sclk | output | 1 | SPI clock, idles high |
| csN | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to converter |
| miso | input | 1 | SPI data from converter |

## Verification
On every cycle the assertions check the pin-level rules. The select pins must hold steady during a transfer and show configuration mode exactly when the strobe is high. The SPI clock must idle high while deselected, the strobe must be high when idle, and `done` must be a single-cycle pulse. Some behaviour only the bench scenarios can show: the byte contents and order of each operation, the strobe lead and tail lengths, the scaling and sign extension at each resolution, the early exit of startup on a bad read-back, and whether requests made while busy are dropped.

// File: rtl/rdc_pkg.sv
`timescale 1ns/1ps
package rdc_pkg;
  typedef enum logic [2:0] {
    OP_POS = 3'd0, OP_VEL = 3'd1, OP_WR = 3'd2, OP_RD = 3'd3, OP_FAULT = 3'd4, OP_INIT = 3'd5
  } op_e;

  localparam logic [1:0] MS_POS = 2'b00;
  localparam logic [1:0] MS_VEL = 2'b01;
  localparam logic [1:0] MS_CFG = 2'b10;

  typedef enum logic [2:0] {U_SLO, U_SHI, U_X1, U_X2, U_CHK, U_END} ukind_e;
  typedef enum logic [1:0] {RK_POS, RK_VEL, RK_REG} rkind_e;

  typedef struct packed {
    ukind_e     kind;
    logic [1:0] mode;
    logic [7:0] tx0;
    logic [7:0] tx1;
    logic       longWait;
  } uop_t;

  typedef struct packed {
    logic       xferGo;
    logic       twoByte;
    logic [7:0] tx0;
    logic [7:0] tx1;
    logic       capRes;
    rkind_e     resKind;
    logic       loadCfg;
    logic [1:0] cfgRes;
    logic       cfgHyst;
  } strobe_t;

  localparam logic [7:0] ADDR_FLAG = 8'h80;
  localparam logic [7:0] REG_CTRL  = 8'h92;
  localparam logic [7:0] REG_FREQ  = 8'h91;
  localparam logic [7:0] REG_RESET = 8'hF0;
  localparam logic [7:0] REG_FLT   = 8'hFF;
  localparam logic [7:0] RD_FILL   = 8'hFF;
  localparam logic [7:0] CTRL_BASE = 8'h7C;
endpackage

// File: rtl/rdc_ctrl.sv
`timescale 1ns/1ps
module rdc_ctrl import rdc_pkg::*; #(
  parameter int PRE_CYC  = 151,
  parameter int POST_CYC = 53
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [7:0] cmdAddr,
  input  logic [7:0] cmdData,
  input  logic [1:0] resCode,
  input  logic [7:0] freqWord,
  input  logic       xferDone,
  input  logic [7:0] rxLow,
  output strobe_t    st,
  output logic       busy,
  output logic       done,
  output logic       initErr,
  output logic [1:0] modeSel,
  output logic       sampleN
);
  localparam int MAX_CYC = (PRE_CYC > POST_CYC) ? PRE_CYC : POST_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WAIT, S_XFER, S_FIN} state_e;

  state_e     state;
  op_e        op;
  logic [3:0] pc;
  logic [CNT_W-1:0] cnt;
  logic [7:0] addrR, dataR, fcwR;
  logic [1:0] resR;
  uop_t       u;
  logic       accept;

  function automatic uop_t decode(op_e o, logic [3:0] p, logic [7:0] a, logic [7:0] d,
                                  logic [1:0] r, logic [7:0] f);
    uop_t x;
    x.kind = U_END; x.mode = MS_CFG; x.tx0 = 8'h00; x.tx1 = 8'h00; x.longWait = 1'b0;
    case (o)
      OP_POS, OP_VEL: case (p)
        4'd0: begin x.kind = U_SLO; x.longWait = 1'b1; end
        4'd1: begin x.kind = U_X2; x.mode = (o == OP_VEL) ? MS_VEL : MS_POS; end
        4'd2: x.kind = U_SHI;
        default: ;
      endcase
      OP_WR: case (p)
        4'd0: begin x.kind = U_X1; x.tx0 = a | ADDR_FLAG; end
        4'd1: begin x.kind = U_X1; x.tx0 = d & ~ADDR_FLAG; end
        default: ;
      endcase
      OP_RD: if (p == 4'd0) begin x.kind = U_X2; x.tx0 = a | ADDR_FLAG; x.tx1 = RD_FILL; end
      OP_FAULT: case (p)
        4'd0, 4'd3: x.kind = U_SLO;
        4'd1, 4'd4: x.kind = U_SHI;
        4'd2: begin x.kind = U_X2; x.tx0 = REG_FLT; x.tx1 = RD_FILL; end
        default: ;
      endcase
      OP_INIT: case (p)
        4'd0: begin x.kind = U_X1; x.tx0 = REG_CTRL; end
        4'd1: begin x.kind = U_X1; x.tx0 = CTRL_BASE | {6'b0, r}; end
        4'd2: begin x.kind = U_X2; x.tx0 = REG_CTRL; x.tx1 = RD_FILL; end
        4'd3: x.kind = U_CHK;
        4'd4: begin x.kind = U_X1; x.tx0 = REG_FREQ; end
        4'd5: begin x.kind = U_X1; x.tx0 = f & ~ADDR_FLAG; end
        4'd6: begin x.kind = U_X1; x.tx0 = REG_RESET; end
        4'd7: begin x.kind = U_X1; x.tx0 = 8'h00; end
        default: ;
      endcase
      default: ;
    endcase
    return x;
  endfunction

  always_comb u = decode(op, pc, addrR, dataR, resR, fcwR);
  assign accept = (state == S_IDLE) && cmdValid && (cmdOp <= 3'd5);

  always_comb begin
    st         = '0;
    st.xferGo  = (state == S_FETCH) && (u.kind == U_X1 || u.kind == U_X2);
    st.twoByte = (u.kind == U_X2);
    st.tx0     = u.tx0;
    st.tx1     = u.tx1;
    st.capRes  = (state == S_FIN) && (op != OP_WR) && (op != OP_INIT);
    st.resKind = (op == OP_POS) ? RK_POS : (op == OP_VEL) ? RK_VEL : RK_REG;
    st.loadCfg = (accept && cmdOp == 3'd5) ||
                 ((state == S_FIN) && op == OP_WR && (addrR | ADDR_FLAG) == REG_CTRL);
    st.cfgRes  = accept ? resCode : dataR[1:0];
    st.cfgHyst = accept ? CTRL_BASE[4] : dataR[4];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; op <= OP_POS; pc <= '0; cnt <= '0;
      addrR <= '0; dataR <= '0; fcwR <= '0; resR <= '0;
      busy <= 1'b0; done <= 1'b0; initErr <= 1'b0;
      modeSel <= MS_CFG; sampleN <= 1'b1;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          op <= op_e'(cmdOp); addrR <= cmdAddr; dataR <= cmdData;
          resR <= resCode; fcwR <= freqWord; pc <= '0;
          busy <= 1'b1; state <= S_FETCH;
          if (cmdOp == 3'd5) initErr <= 1'b0;
        end
        S_FETCH: case (u.kind)
          U_SLO: begin
            sampleN <= 1'b0; pc <= pc + 4'd1; state <= S_WAIT;
            cnt <= u.longWait ? CNT_W'(PRE_CYC) : CNT_W'(POST_CYC);
          end
          U_SHI: begin
            sampleN <= 1'b1; pc <= pc + 4'd1; state <= S_WAIT; cnt <= CNT_W'(POST_CYC);
          end
          U_X1, U_X2: begin
            modeSel <= u.mode; pc <= pc + 4'd1; state <= S_XFER;
          end
          U_CHK: if (rxLow[7]) begin
            initErr <= 1'b1; state <= S_FIN;
          end else pc <= pc + 4'd1;
          default: state <= S_FIN;
        endcase
        S_WAIT: if (cnt <= CNT_W'(1)) state <= S_FETCH; else cnt <= cnt - CNT_W'(1);
        S_XFER: if (xferDone) state <= S_FETCH;
        S_FIN: begin done <= 1'b1; busy <= 1'b0; state <= S_IDLE; end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdc_datapath.sv
`timescale 1ns/1ps
module rdc_datapath import rdc_pkg::*; #(
  parameter int SCLK_HALF = 2,
  parameter int WORD_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic              miso,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  output logic              xferDone,
  output logic [7:0]        rxLow,
  output logic [WORD_W-1:0] result,
  output logic [1:0]        resSel
);
  localparam int DIV_W = (SCLK_HALF > 2) ? $clog2(SCLK_HALF) : 1;
  localparam int BIT_W = $clog2(WORD_W + 1);

  logic              active, hystR;
  logic [DIV_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitCnt, nBits;
  logic [WORD_W-1:0] txSh, rxSh, rxWord, posVal, velVal;
  logic [3:0]        shAmt;
  logic              tick;

  assign tick  = (divCnt == DIV_W'(SCLK_HALF - 1));
  assign rxLow = rxWord[7:0];
  assign shAmt = 4'd6 - {1'b0, resSel, 1'b0};

  always_comb begin
    posVal = hystR ? (rxWord >> shAmt) : rxWord;
    velVal = WORD_W'($signed(rxWord) >>> shAmt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0; sclk <= 1'b1; csN <= 1'b1; mosi <= 1'b0; xferDone <= 1'b0;
      divCnt <= '0; bitCnt <= '0; nBits <= '0; txSh <= '0; rxSh <= '0; rxWord <= '0;
      result <= '0; resSel <= 2'd1; hystR <= 1'b1;
    end else begin
      xferDone <= 1'b0;
      if (st.xferGo) begin
        active <= 1'b1; csN <= 1'b0; divCnt <= '0; bitCnt <= '0;
        nBits  <= st.twoByte ? BIT_W'(16) : BIT_W'(8);
        txSh   <= {st.tx0, st.tx1};
      end else if (active) begin
        divCnt <= tick ? '0 : divCnt + DIV_W'(1);
        if (tick) begin
          if (bitCnt == nBits) begin
            active <= 1'b0; csN <= 1'b1; xferDone <= 1'b1; rxWord <= rxSh;
          end else if (sclk) begin
            sclk <= 1'b0; mosi <= txSh[WORD_W-1];
          end else begin
            sclk   <= 1'b1;
            rxSh   <= {rxSh[WORD_W-2:0], miso};
            txSh   <= {txSh[WORD_W-2:0], 1'b0};
            bitCnt <= bitCnt + BIT_W'(1);
          end
        end
      end
      if (st.capRes) begin
        case (st.resKind)
          RK_POS:  result <= posVal;
          RK_VEL:  result <= velVal;
          default: result <= {{(WORD_W-8){1'b0}}, rxWord[7:0]};
        endcase
      end
      if (st.loadCfg) begin
        resSel <= st.cfgRes; hystR <= st.cfgHyst;
      end
    end
  end
endmodule

// File: rtl/rdc_host.sv
`timescale 1ns/1ps
module rdc_host import rdc_pkg::*; #(
  parameter int SYS_CLK_PS  = 5000,
  parameter int CONV_CLK_PS = 122070,
  parameter int SCLK_HALF   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  input  logic [7:0]  cmdAddr,
  input  logic [7:0]  cmdData,
  input  logic [1:0]  resCode,
  input  logic [7:0]  freqWord,
  output logic        busy,
  output logic        done,
  output logic [15:0] result,
  output logic        initErr,
  output logic [1:0]  modeSel,
  output logic        sampleN,
  output logic [1:0]  resSel,
  output logic        sclk,
  output logic        csN,
  output logic        mosi,
  input  logic        miso
);
  localparam int PRE_CYC  = (6 * CONV_CLK_PS + 20000 + SYS_CLK_PS - 1) / SYS_CLK_PS;
  localparam int POST_CYC = (2 * CONV_CLK_PS + 20000 + SYS_CLK_PS - 1) / SYS_CLK_PS;

  strobe_t    st;
  logic       xferDone;
  logic [7:0] rxLow;

  rdc_ctrl #(.PRE_CYC(PRE_CYC), .POST_CYC(POST_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .resCode(resCode), .freqWord(freqWord), .xferDone(xferDone),
    .rxLow(rxLow), .st(st), .busy(busy), .done(done), .initErr(initErr),
    .modeSel(modeSel), .sampleN(sampleN)
  );

  rdc_datapath #(.SCLK_HALF(SCLK_HALF), .WORD_W(16)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .miso(miso), .sclk(sclk), .csN(csN), .mosi(mosi),
    .xferDone(xferDone), .rxLow(rxLow), .result(result), .resSel(resSel)
  );
endmodule

// File: rtl/rdc_host_checker.sv
`timescale 1ns/1ps
module rdc_host_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       csN,
  input logic       sclk,
  input logic       sampleN,
  input logic [1:0] modeSel
);
  p_mode_stable_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN)) |-> $stable(modeSel));
  p_cfg_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && sampleN) |-> (modeSel == 2'b10));
  p_sample_mode_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !sampleN) |-> (modeSel != 2'b10));
  p_idle_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sampleN);
  p_sclk_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);
  p_cs_in_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind rdc_host rdc_host_checker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .csN(csN),
  .sclk(sclk), .sampleN(sampleN), .modeSel(modeSel)
);

// File: tb/tb_rdc_host.sv
`timescale 1ns/1ps
module tb_rdc_host;
  logic clk = 1'b0, rstN = 1'b0, cmdValid = 1'b0, miso = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [7:0] cmdAddr = '0, cmdData = '0, freqWord = '0;
  logic [1:0] resCode = '0;
  logic busy, done, initErr, sampleN, sclk, csN, mosi;
  logic [1:0] modeSel, resSel;
  logic [15:0] result;

  int checks = 0, errors = 0;
  always #2.5 clk = ~clk;

  rdc_host dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .resCode(resCode), .freqWord(freqWord), .busy(busy), .done(done),
    .result(result), .initErr(initErr), .modeSel(modeSel), .sampleN(sampleN),
    .resSel(resSel), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso)
  );

  // Behavioural converter: shifts respWord out, collects what the host sends.
  logic [15:0] respWord = '0, sOut = '0, sIn = '0;
  logic [1:0]  sMode = '0;
  int sBits = 0;
  int got[$];
  int exq[$];
  always @(negedge csN) begin sOut = respWord; sIn = '0; sBits = 0; end
  always @(negedge sclk) if (!csN) begin miso = sOut[15]; sOut = {sOut[14:0], 1'b0}; end
  always @(posedge sclk) if (!csN) begin sIn = {sIn[14:0], mosi}; sBits++; sMode = modeSel; end
  always @(posedge csN) if (rstN) got.push_back((sBits << 24) | (int'(sMode) << 16) | int'(sIn));

  // Per-clock comparison against the idle/strobe model.
  int leadLo = 0, tail = 0, falls = 0, dones = 0, idleBad = 0, busySeen = 0;
  bit seenCs = 0, prevSn = 1;
  always @(negedge clk) if (rstN) begin
    if (!busy && (!csN || !sclk || !sampleN)) idleBad++;
    if (!sampleN && csN && !seenCs) leadLo++;
    if (!csN) begin seenCs = 1; tail = 0; end
    else if (seenCs && sampleN && busy) tail++;
    if (prevSn && !sampleN) falls++;
    prevSn = sampleN;
    if (done) dones++;
    if (busy) busySeen++;
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int xf(int nb, int mode, int val);
    return (nb << 24) | (mode << 16) | val;
  endfunction

  task automatic cmpXfers(string tag);
    chk(got.size() == exq.size(), {tag, " transfer count"}, got.size(), exq.size());
    for (int i = 0; i < exq.size() && i < got.size(); i++)
      chk(got[i] == exq[i], {tag, " transfer"}, got[i], exq[i]);
    got.delete(); exq.delete();
  endtask

  task automatic clrTrack();
    leadLo = 0; tail = 0; falls = 0; dones = 0; seenCs = 0; busySeen = 0;
  endtask

  task automatic runCmd(int op, logic [7:0] a, logic [7:0] d, logic [15:0] resp);
    int n;
    respWord = resp;
    @(negedge clk);
    clrTrack();
    cmdValid = 1'b1; cmdOp = 3'(op); cmdAddr = a; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(n < 5000, "R12 done seen", n, 0);
  endtask

  // Sample-read framing: lead >= 6 tck + 20 ns, tail >= 2 tck + 20 ns at 5 ns/clock.
  task automatic chkFrame(string tag);
    chk(leadLo * 5000 >= 6 * 122070 + 20000, {tag, " R4 lead"}, leadLo, 151);
    chk(tail * 5000 >= 2 * 122070 + 20000, {tag, " R4 tail"}, tail, 53);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R12 actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // Reset state: R1 R7 R11 R12
    chk(!busy && !done, "R12 reset idle", {busy, done}, 0);
    chk(csN && sclk && sampleN, "R11 reset pins", {csN, sclk, sampleN}, 3'b111);
    chk(modeSel == 2'b10, "R1 reset mode", modeSel, 2'b10);
    chk(resSel == 2'b01, "R7 reset resolution", resSel, 2'b01);
    rstN = 1'b1;
    @(negedge clk);
    got.delete();

    // R8 startup, 14-bit, frequency word with bit 7 cleared on the wire
    resCode = 2'd2; freqWord = 8'hA8;
    exq = '{xf(8,2,'h92), xf(8,2,('h7E & ~3) | 2), xf(16,2,'h92FF), xf(8,2,'h91),
            xf(8,2,'h28), xf(8,2,'hF0), xf(8,2,'h00)};
    runCmd(5, 0, 0, 16'h007A);
    cmpXfers("R8 startup");
    chk(!initErr, "R9 startup ok", initErr, 0);
    chk(resSel == 2'd2, "R7 startup resolution", resSel, 2);

    // R6 position with hysteresis at 14 bits
    exq = '{xf(16,0,0)};
    runCmd(0, 0, 0, 16'hABCD);
    cmpXfers("R1 position");
    chk(result == 16'h2AF3, "R6 position hyst", result, 16'h2AF3);
    chkFrame("position");

    // R5 velocity, negative and positive
    exq = '{xf(16,1,0)};
    runCmd(1, 0, 0, 16'hABCD);
    cmpXfers("R1 velocity");
    chk(result == 16'hEAF3, "R5 velocity negative", result, 16'hEAF3);
    chkFrame("velocity");
    runCmd(1, 0, 0, 16'h1234);
    got.delete();
    chk(result == 16'h048D, "R5 velocity positive", result, 16'h048D);

    // R2 R7 control write: 16 bits, hysteresis off
    exq = '{xf(8,2,'h92), xf(8,2,'h63)};
    runCmd(2, 8'h12, 8'hE3, 0);
    cmpXfers("R2 control write");
    chk(resSel == 2'd3, "R7 write resolution", resSel, 3);
    runCmd(0, 0, 0, 16'h8001);
    got.delete();
    chk(result == 16'h8001, "R6 position no hyst", result, 16'h8001);
    runCmd(1, 0, 0, 16'h8001);
    got.delete();
    chk(result == 16'h8001, "R5 velocity 16 bit", result, 16'h8001);

    // R7 write elsewhere leaves resolution alone
    exq = '{xf(8,2,'h88), xf(8,2,'h55)};
    runCmd(2, 8'h08, 8'hD5, 0);
    cmpXfers("R2 other write");
    chk(resSel == 2'd3, "R7 other write ignored", resSel, 3);

    // 12 bits, hysteresis on
    runCmd(2, 8'h92, 8'h11, 0);
    got.delete();
    chk(resSel == 2'd1, "R7 resolution 12", resSel, 1);
    runCmd(0, 0, 0, 16'hFFF0);
    got.delete();
    chk(result == 16'h0FFF, "R6 position 12 bit", result, 16'h0FFF);
    runCmd(1, 0, 0, 16'hFFF0);
    got.delete();
    chk(result == 16'hFFFF, "R5 velocity 12 bit", result, 16'hFFFF);

    // R3 register read
    exq = '{xf(16,2,'h88FF)};
    runCmd(3, 8'h08, 0, 16'h335C);
    cmpXfers("R3 read");
    chk(result == 16'h005C, "R3 read value", result, 16'h005C);

    // R10 fault read and clear
    exq = '{xf(16,2,'hFFFF)};
    runCmd(4, 0, 0, 16'h00A5);
    cmpXfers("R10 fault");
    chk(result == 16'h00A5, "R10 fault value", result, 16'h00A5);
    chk(falls == 2, "R10 strobe pulses", falls, 2);

    // R12 request while busy is dropped
    respWord = 16'h4000;
    @(negedge clk);
    clrTrack();
    cmdValid = 1'b1; cmdOp = 3'd0;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (20) @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd2; cmdAddr = 8'h92; cmdData = 8'h00;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (600) @(negedge clk);
    exq = '{xf(16,0,0)};
    cmpXfers("R12 busy drop");
    chk(dones == 1, "R12 single done", dones, 1);
    chk(resSel == 2'd1, "R12 dropped write", resSel, 1);

    // R12 undefined op ignored
    @(negedge clk);
    clrTrack();
    cmdValid = 1'b1; cmdOp = 3'd6;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (50) @(negedge clk);
    chk(busySeen == 0 && dones == 0, "R12 undefined op", busySeen + dones, 0);
    chk(got.size() == 0, "R12 undefined op bus", got.size(), 0);

    // R9 startup read-back failure
    resCode = 2'd0; freqWord = 8'h10;
    exq = '{xf(8,2,'h92), xf(8,2,'h7C), xf(16,2,'h92FF)};
    runCmd(5, 0, 0, 16'h0080);
    cmpXfers("R9 startup abort");
    chk(initErr, "R9 error flag", initErr, 1);

    chk(idleBad == 0, "R11 idle pins per clock", idleBad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule